// File: doc/BRIEF.md
# Program Fetch Address Mapper

This block decides, for every instruction fetch and every table read (MOVC) in a 64 KB 8051-style program space, which memory answers: the low internal code memory, the boot ROM in the upper half, or external program memory reached over the multiplexed bus. It latches the external-access strap and the security setting while reset is held. It keeps a boot-mapping enable that reset forces on. It presents the reset vector that the CPU core loads.

A request is accepted when `req_valid` is high and `req_ready` is high. One cycle later exactly one outcome is reported, registered, with `acc_vld`: one of the three selects, or `movc_blk` when the security rule refuses the read. An external access raises `ext_req` together with the captured `ext_addr`. The request stays up until the bus logic answers with `ext_ack`, and no new request is accepted in the meantime. The read byte from the selected memory passes through to `rdata`, except after a refused read, when `rdata` shows all ones.

Top module: `prog_space_mapper`

## Requirements
- R1: `ea_pin` and `lock_pin` are sampled only while `rst_n` is low and are ignored afterwards. `reset_vector` is 16'hF800 when the latched strap is 1 and 16'h0000 when it is 0.
- R2: With the latched strap at 0, every accepted access, at any address, selects external memory.
- R3: With the latched strap at 1, an accepted access with address bit 15 at 0 selects the low internal code memory.
- R4: With the latched strap at 1, an access with address bit 15 at 1 selects the boot ROM when the boot-mapping enable is 1 and external memory when it is 0. Reset sets the enable to 1. `boot_en_we` high loads `boot_en_d` into it at the clock edge, and an access accepted in the same cycle uses the old value.
- R5: The outcome is registered one cycle after acceptance. With `acc_vld` high, exactly one of `sel_low`, `sel_boot`, `sel_ext`, `movc_blk` is high. With `acc_vld` low, all four are low.
- R6: With `lock_pin` latched at 1, a MOVC (`req_movc`=1) to an internal target is refused when the last accepted fetch (`req_movc`=0) came from external memory. A refused read gives `movc_blk` and no select. Before the first fetch, the fetch source counts as external exactly when the latched strap is 0.
- R7: `viol` goes high on the first refused read and stays high until reset.
- R8: `ext_req` rises in the same cycle as `sel_ext` and holds until a cycle with `ext_ack` high. While it is high, `req_ready` is low and requests are ignored. `ext_addr` changes only when an external access is accepted.
- R9: `rdata` equals `code_rdata` unless `movc_blk` is high, in which case it is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ea_pin | input | 1 | external-access strap level, sampled in reset |
| lock_pin | input | 1 | security level 2 setting, sampled in reset |
| boot_en_we | input | 1 | write strobe for the boot-mapping enable |
| boot_en_d | input | 1 | new value for the boot-mapping enable |
| req_valid | input | 1 | access request |
| req_movc | input | 1 | 1 = MOVC table read, 0 = instruction fetch |
| req_addr | input | 16 | program-space address |
| req_ready | output | 1 | a request is accepted this cycle |
| ext_ack | input | 1 | external bus has finished the access |
| code_rdata | input | 8 | byte returned by the selected memory |
| acc_vld | output | 1 | outcome of an accepted access is valid |
| sel_low | output | 1 | low internal code memory selected |
| sel_boot | output | 1 | boot ROM selected |
| sel_ext | output | 1 | external program memory selected |
| movc_blk | output | 1 | MOVC refused by the security rule |
| viol | output | 1 | sticky record of a refused read |
| ext_req | output | 1 | external strobe request, held until acknowledged |
| ext_addr | output | 16 | address driven to the external bus |
| rdata | output | 8 | returned byte, forced to FFh when refused |
| reset_vector | output | 16 | start address after reset |

## Verification
A wrong latched strap shows at once on `reset_vector` and on the first select after reset. A stale boot-mapping enable shows on the first upper-half access after a write. A wrong record of the last fetch source stays hidden until a MOVC follows an external fetch with the lock set. At that point it shows as a missing or spurious `movc_blk`, and from then on as a wrong `viol` on every cycle. The bench therefore compares all outputs against its own model on every clock, so each divergence is reported in the cycle it first reaches a port.

// File: rtl/prog_space_mapper.sv
module prog_space_mapper #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] BOOT_VEC = 16'hF800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ea_pin,
  input  logic          lock_pin,
  input  logic          boot_en_we,
  input  logic          boot_en_d,
  input  logic          req_valid,
  input  logic          req_movc,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  input  logic          ext_ack,
  input  logic [DW-1:0] code_rdata,
  output logic          acc_vld,
  output logic          sel_low,
  output logic          sel_boot,
  output logic          sel_ext,
  output logic          movc_blk,
  output logic          viol,
  output logic          ext_req,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] reset_vector
);

  logic ea_q, lock_q, boot_en, exec_ext;
  logic take, upper, tgt_low, tgt_boot, tgt_ext, deny;

  assign req_ready = !ext_req;
  assign take      = req_valid && req_ready;
  assign upper     = req_addr[AW-1];
  assign tgt_low   = ea_q && !upper;
  assign tgt_boot  = ea_q && upper && boot_en;
  assign tgt_ext   = !ea_q || (upper && !boot_en);
  assign deny      = req_movc && lock_q && exec_ext && !tgt_ext;

  assign rdata        = movc_blk ? {DW{1'b1}} : code_rdata;
  assign reset_vector = ea_q ? BOOT_VEC : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q     <= ea_pin;
      lock_q   <= lock_pin;
      boot_en  <= 1'b1;
      exec_ext <= !ea_pin;
      acc_vld  <= 1'b0;
      sel_low  <= 1'b0;
      sel_boot <= 1'b0;
      sel_ext  <= 1'b0;
      movc_blk <= 1'b0;
      viol     <= 1'b0;
      ext_req  <= 1'b0;
      ext_addr <= '0;
    end else begin
      if (boot_en_we) boot_en <= boot_en_d;
      acc_vld  <= take;
      sel_low  <= take && !deny && tgt_low;
      sel_boot <= take && !deny && tgt_boot;
      sel_ext  <= take && tgt_ext;
      movc_blk <= take && deny;
      if (take && deny) viol <= 1'b1;
      if (take && !req_movc) exec_ext <= tgt_ext;
      if (take && tgt_ext) begin
        ext_req  <= 1'b1;
        ext_addr <= req_addr;
      end else if (ext_ack) begin
        ext_req <= 1'b0;
      end
    end
  end

endmodule

module prog_space_mapper_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ea_q,
  input logic          acc_vld,
  input logic          sel_low,
  input logic          sel_boot,
  input logic          sel_ext,
  input logic          movc_blk,
  input logic          viol,
  input logic          ext_req,
  input logic          ext_ack,
  input logic          req_ready,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] reset_vector
);

  // R5
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> $onehot({sel_low, sel_boot, sel_ext, movc_blk}));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> !(sel_low || sel_boot || sel_ext || movc_blk));

  // R2
  strap_low_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_q |-> !(sel_low || sel_boot));

  // R1
  vector_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_q |-> reset_vector[AW-1]);

  // R7
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> ext_req);

  // R8
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_req) |-> sel_ext);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !req_ready);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ext |-> $stable(ext_addr));

  // R6
  refused_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    movc_blk |-> !ext_req);

endmodule

bind prog_space_mapper prog_space_mapper_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ea_q(ea_q), .acc_vld(acc_vld),
  .sel_low(sel_low), .sel_boot(sel_boot), .sel_ext(sel_ext),
  .movc_blk(movc_blk), .viol(viol), .ext_req(ext_req), .ext_ack(ext_ack),
  .req_ready(req_ready), .ext_addr(ext_addr), .reset_vector(reset_vector)
);

// File: tb/prog_space_mapper_test.sv
module prog_space_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 5000;

  logic clk = 0, rst_n = 0;
  logic ea_pin = 1, lock_pin = 1, boot_en_we = 0, boot_en_d = 0;
  logic req_valid = 0, req_movc = 0, ext_ack = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] code_rdata = 8'h5A;
  logic req_ready, acc_vld, sel_low, sel_boot, sel_ext, movc_blk, viol, ext_req;
  logic [15:0] ext_addr, reset_vector;
  logic [7:0] rdata;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  prog_space_mapper uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit m_ea, m_lock, m_boot, m_xe, m_req, m_acc, m_sl, m_sb, m_se, m_blk, m_viol;
  int m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ea = ea_pin; m_lock = lock_pin; m_boot = 1; m_xe = !ea_pin;
      m_req = 0; m_acc = 0; m_sl = 0; m_sb = 0; m_se = 0; m_blk = 0; m_viol = 0;
      m_addr = 0;
    end else begin
      bit take, hi, ext, refuse, old_boot;
      old_boot = m_boot;
      if (boot_en_we) m_boot = boot_en_d;
      take = req_valid && !m_req;
      hi = req_addr >= 16'h8000;
      if (!m_ea) ext = 1;
      else if (hi) ext = !old_boot;
      else ext = 0;
      refuse = req_movc && m_lock && m_xe && !ext;
      m_acc = take;
      m_sl = take && !refuse && !ext && !hi;
      m_sb = take && !refuse && !ext && hi;
      m_se = take && ext;
      m_blk = take && refuse;
      if (m_blk) m_viol = 1;
      if (take && !req_movc) m_xe = ext;
      if (take && ext) begin m_req = 1; m_addr = req_addr; end
      else if (ext_ack) m_req = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check("R1 reset_vector", reset_vector, m_ea ? 16'hF800 : 0);
      check("R5 acc_vld", acc_vld, m_acc);
      check("R3 sel_low", sel_low, m_sl);
      check("R4 sel_boot", sel_boot, m_sb);
      check("R2 sel_ext", sel_ext, m_se);
      check("R6 movc_blk", movc_blk, m_blk);
      check("R7 viol", viol, m_viol);
      check("R8 ext_req", ext_req, m_req);
      check("R8 req_ready", req_ready, !m_req);
      check("R8 ext_addr", ext_addr, m_addr);
      check("R9 rdata", rdata, m_blk ? 8'hFF : code_rdata);
    end
    if (cyc > LIMIT && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic access(input logic [15:0] a, input logic mv);
    req_valid = 1; req_addr = a; req_movc = mv;
    code_rdata = code_rdata + 8'h11;
    step();
    req_valid = 0;
    step();
  endtask

  task automatic ack_after(int n);
    step(n);
    ext_ack = 1; step(); ext_ack = 0; step();
  endtask

  task automatic do_reset(input logic ea, input logic lk);
    rst_n = 0; ea_pin = ea; lock_pin = lk;
    step(3);
    rst_n = 1;
    step();
    ea_pin = !ea; lock_pin = !lk;   // R1: changes after reset are ignored
  endtask

  initial begin
    // strap 1, lock on
    do_reset(1, 1);
    check("R1 vector after reset", reset_vector, 16'hF800);
    check("R7 viol after reset", viol, 0);
    access(16'h0100, 0);             // R3 low fetch
    access(16'h9000, 0);             // R4 boot (enable reset to 1)
    access(16'h0200, 1);             // R6 internal exec, allowed
    boot_en_we = 1; boot_en_d = 0; req_valid = 1; req_addr = 16'hA000; req_movc = 0;
    step();                          // R4 same-cycle write: old value (boot)
    boot_en_we = 0; req_valid = 0; step();
    req_valid = 1; req_addr = 16'h9000; req_movc = 0;
    step();                          // external fetch accepted
    req_addr = 16'h0004;             // held request ignored while busy (R8)
    step(2);
    req_valid = 0;
    ext_ack = 1; step(); ext_ack = 0; step();
    access(16'h0010, 1);             // R6 refused, R9 FFh
    check("R7 viol set", viol, 1);
    access(16'hA000, 1);             // MOVC to external allowed
    ack_after(2);
    access(16'h0004, 0);             // internal fetch
    access(16'h0010, 1);             // allowed now
    check("R7 viol still set", viol, 1);

    // strap 0
    do_reset(0, 1);
    check("R1 vector strap 0", reset_vector, 16'h0000);
    access(16'h0100, 0);             // R2 ext
    ack_after(1);
    access(16'hF000, 1);             // R2 ext, not refused
    ack_after(0);

    // strap 1, lock off
    do_reset(1, 0);
    access(16'h8000, 0);             // boot
    boot_en_we = 1; boot_en_d = 0; step(); boot_en_we = 0;
    access(16'hC000, 0);             // R4 ext
    ack_after(1);
    access(16'h0000, 1);             // R6 lock off: allowed
    check("R7 viol clear", viol, 0);
    step(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule